// File: doc/BRIEF.md
# Symbol-Framed Converter Sample Deserializer

This block receives the one-bit serial output of a line front end's sampling converter on the processor side of the link. The serial line is clocked by an oversampling clock running at 48 times the symbol rate. A separate, asynchronous symbol clock marks where each symbol period begins. Every symbol period is a fixed 48-bit frame: a 16-bit conversion word, 8 filler bits, a second 16-bit conversion word, then 8 more filler bits.

The block resynchronises the symbol clock into the oversampling domain and counts bit positions inside the frame. From each conversion word it takes the 14-bit two's-complement converter result and delivers it sign-extended to 16 bits. A one-cycle valid strobe marks each delivered sample, and a flag tells whether it came from the first (nominal) or the second (extra) conversion. A two-bit pick input selects which of the two conversions are delivered.

Spare bits must read 0 and filler bits must read 1. When either does not, the block sets a sticky framing-error flag, which software-independent logic clears with a dedicated input.

Top module: `adc_frame_rx`

## Requirements
- R1: While reset is asserted, and until a word is delivered, `sample_o` is 0, `sample_vld_o` is 0, `sample_sec_o` is 0 and `frame_err_o` is 0.
- R2: Before the first rising edge of `sym_clk_i` has been detected, no sample is delivered and no framing error is raised, whatever `sdata_i` carries.
- R3: `sym_clk_i` passes through two synchroniser flops. The bit captured on the third rising `clk` edge after `sym_clk_i` rises is frame position 0. Every later detected rise realigns the count to position 0. Without a new rise, the count wraps from 47 to 0.
- R4: Frame positions 0–15 hold the first word and 24–39 hold the second word, each sent MSB first. Positions 16–23 and 40–47 are filler. Word bits 15..2 are the 14-bit two's-complement sample (0x1FFF is positive full scale, 0x2000 is negative full scale). Word bits 1..0 (positions 14, 15, 38, 39) are spare.
- R5: `sample_vld_o` is high for exactly one cycle: the cycle after the edge that captures a delivered word's last bit (position 15 or 39). At that point `sample_o` holds the 14-bit sample sign-extended to 16 bits. `sample_o` does not change in any other cycle.
- R6: `pick_i` is sampled when a word completes. 2'b01 delivers only the first word, 2'b10 only the second, 2'b11 both, and 2'b00 neither. `sample_sec_o` is 0 for a first-word sample and 1 for a second-word sample.
- R7: A spare bit read as 1, or a filler bit read as 0, sets `frame_err_o` in the cycle after the edge that captured it. The flag stays set until it is cleared.
- R8: `err_clr_i` high at a rising edge clears `frame_err_o`. If a framing error is captured at the same edge, the flag stays set.
- R9: A corrupted spare bit does not change the delivered sample value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock (48x symbol rate); serial data is sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| sym_clk_i | input | 1 | Symbol-rate clock, asynchronous to `clk`; its rising edge marks frame start |
| sdata_i | input | 1 | Serial converter data, changing on the falling edge of `clk` |
| pick_i | input | 2 | Conversion selection: 01 first, 10 second, 11 both, 00 none |
| err_clr_i | input | 1 | Clears the sticky framing-error flag |
| sample_o | output | 16 | Last delivered sample, sign-extended |
| sample_vld_o | output | 1 | One-cycle strobe for a newly delivered sample |
| sample_sec_o | output | 1 | 0: sample from first word, 1: from second word |
| frame_err_o | output | 1 | Sticky framing-error flag |

## Verification
The serial stream is driven with full-scale positive and negative extremes, mid scale and minus one, then with random samples. These show whether the sign extension and MSB-first bit ordering are correct. Frames are preceded by a random number of idle bits, so only a block that realigns on every symbol-clock rise recovers the right words. A block that free-runs, or that has the wrong synchroniser latency, delivers shifted values. Each frame is tried under all four pick settings, which separates gating from word tagging. Spare and filler bits are corrupted separately: spare corruption must raise the flag without touching the sample, and filler corruption must raise it in either half of the frame. A clear that coincides with a fresh error shows which of the two wins.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

    localparam int unsigned WORD_BITS   = 16;
    localparam int unsigned SAMPLE_BITS = 14;
    localparam int unsigned FILL_BITS   = 8;
    localparam int unsigned OUT_BITS    = 16;
    localparam int unsigned SYNC_DEPTH  = 2;

    typedef enum logic [1:0] {
        PICK_NONE   = 2'b00,
        PICK_FIRST  = 2'b01,
        PICK_SECOND = 2'b10,
        PICK_BOTH   = 2'b11
    } pick_e;

endpackage

// File: rtl/afr_edge_sync.sv
module afr_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sym_i,
    output logic rise_o
);

    // STAGES synchroniser flops plus one history flop for edge detection
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], sym_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/afr_slot_ctr.sv
module afr_slot_ctr #(
    parameter int unsigned FRAME_LEN = 48,
    parameter int unsigned CNT_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    output logic [CNT_W-1:0] pos_o,
    output logic             live_o
);

    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_LEN - 1);

    typedef struct packed {
        logic             lock;
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    ctr_t s_d, s_q;
    logic [CNT_W-1:0] pos;

    always_comb begin
        pos        = rise_i ? '0 : s_q.cnt;
        s_d.lock   = s_q.lock | rise_i;
        s_d.cnt    = (pos == LAST_POS) ? '0 : pos + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pos_o  = pos;
    assign live_o = s_q.lock | rise_i;

endmodule

// File: rtl/afr_word_unpack.sv
module afr_word_unpack #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned DATA_W = 14,
    parameter int unsigned FILL_W = 8,
    parameter int unsigned OUT_W  = 16,
    parameter int unsigned CNT_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             live_i,
    input  logic [CNT_W-1:0] pos_i,
    input  logic             bit_i,
    input  logic [1:0]       pick_i,
    input  logic             clr_i,
    output logic [OUT_W-1:0] sample_o,
    output logic             vld_o,
    output logic             sec_o,
    output logic             err_o
);

    localparam int unsigned SPARE_W = WORD_W - DATA_W;
    localparam logic [CNT_W-1:0] W1_LAST   = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] W1_SPARE  = CNT_W'(WORD_W - SPARE_W);
    localparam logic [CNT_W-1:0] W2_FIRST  = CNT_W'(WORD_W + FILL_W);
    localparam logic [CNT_W-1:0] W2_LAST   = CNT_W'(2 * WORD_W + FILL_W - 1);
    localparam logic [CNT_W-1:0] W2_SPARE  = CNT_W'(2 * WORD_W + FILL_W - SPARE_W);

    typedef struct packed {
        logic [WORD_W-2:0] sh;
        logic [OUT_W-1:0]  smp;
        logic              vld;
        logic              sec;
        logic              err;
    } unp_t;

    unp_t s_d, s_q;

    logic              in_w1, in_w2, is_fill, is_spare, bad_bit;
    logic              done1, done2, take;
    logic [DATA_W-1:0] raw;
    logic [OUT_W-1:0]  ext;

    // at a word's last bit, the shifter holds word bits 15..1; bits 15..2 are data
    assign raw = s_q.sh[WORD_W-2 -: DATA_W];

    generate
        if (OUT_W > DATA_W) begin : g_sext
            assign ext = {{(OUT_W-DATA_W){raw[DATA_W-1]}}, raw};
        end else begin : g_trunc
            assign ext = raw[DATA_W-1 -: OUT_W];
        end
    endgenerate

    always_comb begin
        in_w1    = (pos_i <= W1_LAST);
        in_w2    = (pos_i >= W2_FIRST) && (pos_i <= W2_LAST);
        is_fill  = !in_w1 && !in_w2;
        is_spare = (in_w1 && pos_i >= W1_SPARE) || (in_w2 && pos_i >= W2_SPARE);
        bad_bit  = live_i && ((is_spare && bit_i) || (is_fill && !bit_i));
        done1    = live_i && (pos_i == W1_LAST);
        done2    = live_i && (pos_i == W2_LAST);
        take     = (done1 && pick_i[0]) || (done2 && pick_i[1]);

        s_d      = s_q;
        s_d.sh   = {s_q.sh[WORD_W-3:0], bit_i};
        s_d.vld  = take;
        if (take) begin
            s_d.smp = ext;
            s_d.sec = done2;
        end
        if (bad_bit)    s_d.err = 1'b1;
        else if (clr_i) s_d.err = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sample_o = s_q.smp;
    assign vld_o    = s_q.vld;
    assign sec_o    = s_q.sec;
    assign err_o    = s_q.err;

endmodule

// File: rtl/adc_frame_rx.sv
module adc_frame_rx
    import adc_frame_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_BITS,
    parameter int unsigned DATA_W = SAMPLE_BITS,
    parameter int unsigned FILL_W = FILL_BITS,
    parameter int unsigned OUT_W  = OUT_BITS,
    parameter int unsigned SYNC_N = SYNC_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_clk_i,
    input  logic             sdata_i,
    input  logic [1:0]       pick_i,
    input  logic             err_clr_i,
    output logic [OUT_W-1:0] sample_o,
    output logic             sample_vld_o,
    output logic             sample_sec_o,
    output logic             frame_err_o
);

    localparam int unsigned FRAME_LEN = 2 * (WORD_W + FILL_W);
    localparam int unsigned CNT_W     = $clog2(FRAME_LEN);

    logic             rise;
    logic             live;
    logic [CNT_W-1:0] pos;

    afr_edge_sync #(.STAGES(SYNC_N)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sym_i  (sym_clk_i),
        .rise_o (rise)
    );

    afr_slot_ctr #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise_i (rise),
        .pos_o  (pos),
        .live_o (live)
    );

    afr_word_unpack #(
        .WORD_W (WORD_W),
        .DATA_W (DATA_W),
        .FILL_W (FILL_W),
        .OUT_W  (OUT_W),
        .CNT_W  (CNT_W)
    ) u_unp (
        .clk      (clk),
        .rst_n    (rst_n),
        .live_i   (live),
        .pos_i    (pos),
        .bit_i    (sdata_i),
        .pick_i   (pick_i),
        .clr_i    (err_clr_i),
        .sample_o (sample_o),
        .vld_o    (sample_vld_o),
        .sec_o    (sample_sec_o),
        .err_o    (frame_err_o)
    );

endmodule

// File: rtl/adc_frame_rx_chk.sv
module adc_frame_rx_chk #(
    parameter int unsigned OUT_W  = 16,
    parameter int unsigned DATA_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       pick_i,
    input logic             err_clr_i,
    input logic [OUT_W-1:0] sample_o,
    input logic             sample_vld_o,
    input logic             sample_sec_o,
    input logic             frame_err_o
);

    // R5: a delivered sample is strobed for a single cycle
    a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld_o |=> !sample_vld_o);

    // R5: the sample register only moves together with the strobe
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld_o |-> $stable(sample_o));

    // R6: first-word samples only when the low pick bit was set
    a_r6_first_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld_o && !sample_sec_o) |-> $past(pick_i[0]));

    // R6: second-word samples only when the high pick bit was set
    a_r6_second_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld_o && sample_sec_o) |-> $past(pick_i[1]));

    // R7: the error flag holds until a clear arrives
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err_o && !err_clr_i) |=> frame_err_o);

    // R4: the upper bits of the output always replicate the sample sign
    a_r4_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld_o |-> ((sample_o[OUT_W-1:DATA_W-1] == '0) ||
                          (sample_o[OUT_W-1:DATA_W-1] == '1)));

endmodule

bind adc_frame_rx adc_frame_rx_chk #(.OUT_W(OUT_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pick_i       (pick_i),
    .err_clr_i    (err_clr_i),
    .sample_o     (sample_o),
    .sample_vld_o (sample_vld_o),
    .sample_sec_o (sample_sec_o),
    .frame_err_o  (frame_err_o)
);

// File: tb/sim_adc_frame_rx.sv
`timescale 1ns/1ps
module sim_adc_frame_rx;
    import adc_frame_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sym_clk_i;
    logic        sdata_i;
    logic [1:0]  pick_i;
    logic        err_clr_i;
    logic [15:0] sample_o;
    logic        sample_vld_o;
    logic        sample_sec_o;
    logic        frame_err_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic        exp_err = 1'b0;
    logic [15:0] last_smp = 16'h0;

    always #5 clk = ~clk;

    adc_frame_rx u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .sym_clk_i    (sym_clk_i),
        .sdata_i      (sdata_i),
        .pick_i       (pick_i),
        .err_clr_i    (err_clr_i),
        .sample_o     (sample_o),
        .sample_vld_o (sample_vld_o),
        .sample_sec_o (sample_sec_o),
        .frame_err_o  (frame_err_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] sx(input logic [13:0] d);
        return {{2{d[13]}}, d};
    endfunction

    // frame layout per R4: word1 at 0..15, filler 16..23, word2 24..39, filler 40..47
    function automatic logic fbit(input logic [13:0] d1, input logic [13:0] d2, input int i);
        logic [15:0] w1, w2;
        w1 = {d1, 2'b00};
        w2 = {d2, 2'b00};
        if (i < 16)      return w1[15-i];
        else if (i < 24) return 1'b1;
        else if (i < 40) return w2[39-i];
        else             return 1'b1;
    endfunction

    // checks a word boundary: delivery gated by the pick bit (R5, R6)
    task automatic word_check(input bit want, input bit sec, input logic [13:0] d);
        if (want) begin
            chk(sample_vld_o == 1'b1, "R5 strobe", 32'(sample_vld_o), 32'd1);
            chk(sample_sec_o == sec, "R6 word tag", 32'(sample_sec_o), 32'(sec));
            chk(sample_o == sx(d), "R3 R4 sample value", 32'(sample_o), 32'(sx(d)));
            last_smp = sx(d);
        end else begin
            chk(sample_vld_o == 1'b0, "R6 gated strobe", 32'(sample_vld_o), 32'd0);
            chk(sample_o == last_smp, "R5 hold", 32'(sample_o), 32'(last_smp));
        end
    endtask

    // gap idle ones, two lead bits with the symbol clock raised, then 48 frame bits
    task automatic send_frame(input logic [13:0] d1, input logic [13:0] d2,
                              input int bad, input int clr, input int gap);
        for (int k = 0; k < gap + 2; k++) begin
            @(negedge clk);
            if (k == 0)
                chk(frame_err_o == exp_err, "R7 R8 error flag", 32'(frame_err_o), 32'(exp_err));
            if (k == gap) sym_clk_i = 1'b1;
            sdata_i   = 1'b1;
            err_clr_i = 1'b0;
        end
        for (int i = 0; i < 48; i++) begin
            logic b;
            @(negedge clk);
            if (i == 16) word_check(pick_i[0], 1'b0, d1);
            if (i == 40) word_check(pick_i[1], 1'b1, d2);
            if (i == 20) sym_clk_i = 1'b0;
            b = fbit(d1, d2, i);
            if (i == bad) b = ~b;
            sdata_i   = b;
            err_clr_i = (i == clr);
        end
        if (clr >= 0) exp_err = (bad >= 0) && (clr <= bad);
        else          exp_err = exp_err | (bad >= 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int vld_seen;
        void'($urandom(32'h5eed1));
        rst_n = 1'b0; sym_clk_i = 1'b0; sdata_i = 1'b0; pick_i = PICK_BOTH; err_clr_i = 1'b0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(sample_o == 16'h0, "R1 sample", 32'(sample_o), 32'd0);
        chk(sample_vld_o == 1'b0, "R1 strobe", 32'(sample_vld_o), 32'd0);
        chk(sample_sec_o == 1'b0, "R1 tag", 32'(sample_sec_o), 32'd0);
        chk(frame_err_o == 1'b0, "R1 error", 32'(frame_err_o), 32'd0);
        rst_n = 1'b1;

        // R2: zeros before any symbol-clock rise would break spare/filler rules
        vld_seen = 0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (sample_vld_o) vld_seen++;
        end
        chk(vld_seen == 0, "R2 no delivery before lock", 32'(vld_seen), 32'd0);
        chk(frame_err_o == 1'b0, "R2 no error before lock", 32'(frame_err_o), 32'd0);
        sdata_i = 1'b1;

        // full-scale and mid-scale corners (R4)
        pick_i = PICK_BOTH;
        send_frame(14'h1FFF, 14'h2000, -1, -1, 0);
        send_frame(14'h0000, 14'h3FFF, -1, -1, 3);
        pick_i = PICK_FIRST;
        send_frame(14'h0155, 14'h2AAA, -1, -1, 0);
        pick_i = PICK_SECOND;
        send_frame(14'h1234, 14'h0ABC, -1, -1, 5);
        pick_i = PICK_NONE;
        send_frame(14'h3001, 14'h0FFE, -1, -1, 1);

        // R9 spare corruption keeps the sample; R7 sticky; R8 clear and set-wins
        pick_i = PICK_BOTH;
        send_frame(14'h1ABC, 14'h2DEF, 15, -1, 0);
        send_frame(14'h0321, 14'h3210, -1, -1, 2);
        send_frame(14'h0777, 14'h1888, -1, 5, 0);
        send_frame(14'h2222, 14'h1111, 20, 20, 0);
        send_frame(14'h0042, 14'h3FC0, -1, 5, 0);
        send_frame(14'h1357, 14'h2468, 38, -1, 4);
        send_frame(14'h0100, 14'h0200, 45, 5, 0);

        // constrained random frames
        for (int f = 0; f < 80; f++) begin
            int bad, clr, r;
            pick_i = 2'($urandom_range(0, 3));
            bad = -1;
            clr = -1;
            if ($urandom_range(0, 2) == 0) begin
                r = $urandom_range(0, 19);
                if (r < 2)       bad = 14 + r;
                else if (r < 4)  bad = 36 + r;
                else if (r < 12) bad = 12 + r;
                else             bad = 28 + r;
            end
            if ($urandom_range(0, 3) == 0) clr = 5;
            send_frame(14'($urandom), 14'($urandom), bad, clr, $urandom_range(0, 10));
        end

        // flush frame to check the last error state
        pick_i = PICK_BOTH;
        send_frame(14'h0001, 14'h3FFE, -1, -1, 0);
        @(negedge clk);
        chk(frame_err_o == exp_err, "R7 R8 final error flag", 32'(frame_err_o), 32'(exp_err));

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule